// File: doc/BRIEF.md
# Board Clock and Reset Control Register Target (SPI)

This block is a serial register target that a board-management processor uses to identify a main board and to sequence its peripheral slots. The processor sends 48-bit SPI frames in mode 0: clock idle low, data sampled on the rising edge and changed on the falling edge. Each frame carries a read/write flag, a 15-bit byte address and a 32-bit data word. The block decodes the frame and serves a small register map. The map holds constant identity words, general storage, a link handshake word and a command-driven clock and reset control word.

The control word does not hold the bits written to it. Each controlled item has a pair of one-shot command bits, one that turns it on and one that turns it off. Writing a 1 to a command bit changes a status flop. The status flops drive the slot clock-enable pins, the slot reset pins and the PLL reference enable pin. They also read back at low bit positions of the same address.

The SPI pins are sampled in the system clock domain, so SCK must be slower than about one eighth of the system clock. Typical use is 1 MHz SCK with a 100 MHz system clock.

Top module: `board_ctrl_spi`

## Requirements
- R1: A frame is 48 bits, MSB first, framed by an active-low chip select. Frame bit 47 is the write flag (1 = write, 0 = read), bits 46:32 are the byte address and bits 31:0 are the data. On every frame, MISO carries the addressed register's value MSB first. MISO is valid before each of the rising edges 17 to 48 and changes only on falling edges. MISO is 0 whenever chip select is high.
- R2: Four offsets return constant parameter values and ignore writes: 0x00 signature, 0x04 current revision, 0x08 oldest compatible revision and 0x10 build identifier.
- R3: Offsets 0x0C (scratch), 0x30 (DIO direction), 0x34 (serial low) and 0x38 (serial high) are 32-bit read/write storage.
- R4: At offset 0x20, a write with bit 8, 9 or 10 set enables the slot-0 clock, the slot-1 clock or the PLL reference clock respectively. Bits 12, 13 and 14 disable the same three clocks. A read returns their enabled states in bits 0, 1 and 2. The change is already visible on the next frame and on the output pins.
- R5: At offset 0x20, a write with bit 16 or 17 set releases the slot-0 or slot-1 reset. Bits 20 and 21 assert that reset. The asserted state reads back in bits 4 (slot 0) and 5 (slot 1) and drives the slot reset pins.
- R6: When one write sets both bits of a pair, the safe command wins: the clock is disabled or the reset is asserted. A command bit of 0 leaves its item unchanged. All other bits of the word read as 0.
- R7: After reset, all clocks are disabled, both slot resets are asserted (0x20 reads 0x30), all storage reads 0 and the ready flag is 0.
- R8: A write to offset 0x3C stores data bit 0 as the host-ready flag, which drives host_ready_o. A read of 0x3C returns the synchronized partner-detect input in bit 0 and 0 in all other bits.
- R9: Any address other than the ten mapped offsets reads 0, and writes to it change nothing. This includes addresses with bits above bit 5 set and addresses that are not 4-byte aligned.
- R10: If chip select rises before the 48th rising edge, the frame performs no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCK rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spi_sck_i | input | 1 | SPI serial clock, idle low |
| spi_cs_ni | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | SPI data from controller |
| spi_miso_o | output | 1 | SPI data to controller |
| partner_found_i | input | 1 | Asynchronous partner-detect level |
| host_ready_o | output | 1 | Stored host-ready flag |
| slot_clk_en_o | output | NUM_SLOTS (2) | Clock enable per daughter slot |
| slot_rst_o | output | NUM_SLOTS (2) | Reset level per daughter slot, 1 = held in reset |
| pll_ref_en_o | output | 1 | PLL reference clock enable |

## Verification
A table of frames first reads every constant word and the post-reset state. It then writes distinct patterns to each storage offset and reads them back, so swapped or aliased addresses show up as wrong values. The control word receives a sequence of command patterns: single set bits, matched set and clear pairs, an all-zero command, and mixed release and assert bits for different slots. Each is followed by a readback, which separates the stored-bit behaviour from the set and clear behaviour and checks priority per item. Directed frames then cover writes to aliased, misaligned and read-only addresses, the link word with both values of the partner input, and a write frame cut short after 40 bits.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int FRAME_W = 48;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 15;
  localparam int CNT_W   = 6;
  localparam int HDR_W   = FRAME_W - DATA_W;
  localparam int SR_W    = DATA_W - 1;

  // control word field origins; slot g uses origin+g, PLL uses origin+NUM_SLOTS
  localparam int CLK_ON_LSB   = 8;
  localparam int CLK_OFF_LSB  = 12;
  localparam int RST_OFF_LSB  = 16;
  localparam int RST_ON_LSB   = 20;
  localparam int STAT_CLK_LSB = 0;
  localparam int STAT_RST_LSB = 4;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SIG, SEL_COMPAT, SEL_OLDEST, SEL_SCRATCH, SEL_HASH,
    SEL_CTRL, SEL_DIO, SEL_SER_LO, SEL_SER_HI, SEL_LINK
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if (a[ADDR_W-1:6] == '0 && a[1:0] == 2'b00) begin
      case (a[5:2])
        4'h0: s = SEL_SIG;
        4'h1: s = SEL_COMPAT;
        4'h2: s = SEL_OLDEST;
        4'h3: s = SEL_SCRATCH;
        4'h4: s = SEL_HASH;
        4'h8: s = SEL_CTRL;
        4'hC: s = SEL_DIO;
        4'hD: s = SEL_SER_LO;
        4'hE: s = SEL_SER_HI;
        4'hF: s = SEL_LINK;
        default: s = SEL_NONE;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/bcs_sync.sv
module bcs_sync #(
  parameter int               WIDTH     = 1,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RESET_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bcs_spi_link.sv
module bcs_spi_link
  import bcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              cs_idle_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam logic [CNT_W-1:0] CNT_HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] CNT_HDR_DONE  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_LAST      = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL      = CNT_W'(FRAME_W);

  logic sck_s, cs_s, mosi_s, sck_d;
  logic sck_rise, sck_fall;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [SR_W-1:0]   rx_sr_q;
  logic [DATA_W-1:0] tx_sr_q;
  logic              tx_act_q, hdr_vld_q, hdr_wr_q, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  bcs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b010)) i_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sck_i, cs_ni, mosi_i}),
    .q_o    ({sck_s, cs_s, mosi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d <= 1'b0;
    else         sck_d <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_d & ~cs_s;
  assign sck_fall = ~sck_s & sck_d & ~cs_s;

  // receive shifter and bit counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_sr_q   <= '0;
    end else if (cs_s) begin
      bit_cnt_q <= '0;
    end else if (sck_rise && bit_cnt_q != CNT_FULL) begin
      rx_sr_q   <= {rx_sr_q[SR_W-2:0], mosi_s};
      bit_cnt_q <= bit_cnt_q + 1'b1;
    end
  end

  // header capture: flag and address latched on the 16th rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_vld_q <= 1'b0;
      hdr_wr_q  <= 1'b0;
      addr_q    <= '0;
    end else begin
      hdr_vld_q <= 1'b0;
      if (sck_rise && bit_cnt_q == CNT_HDR_LAST) begin
        hdr_vld_q <= 1'b1;
        hdr_wr_q  <= rx_sr_q[HDR_W-2];
        addr_q    <= {rx_sr_q[ADDR_W-2:0], mosi_s};
      end
    end
  end

  // transmit shifter: loaded once after the header, shifted on falling edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q  <= '0;
      tx_act_q <= 1'b0;
    end else if (cs_s) begin
      tx_act_q <= 1'b0;
    end else if (hdr_vld_q) begin
      tx_sr_q  <= rd_data_i;
      tx_act_q <= 1'b1;
    end else if (sck_fall && tx_act_q && bit_cnt_q > CNT_HDR_DONE) begin
      tx_sr_q  <= {tx_sr_q[DATA_W-2:0], 1'b0};
    end
  end

  // write strobe only on a complete frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      wr_q <= 1'b0;
      if (sck_rise && bit_cnt_q == CNT_LAST) begin
        wr_q    <= hdr_wr_q;
        wdata_q <= {rx_sr_q, mosi_s};
      end
    end
  end

  assign miso_o    = tx_act_q & tx_sr_q[DATA_W-1];
  assign cs_idle_o = cs_s;
  assign addr_o    = addr_q;
  assign wr_o      = wr_q;
  assign wr_data_o = wdata_q;
endmodule

// File: rtl/bcs_clkrst_ctrl.sv
module bcs_clkrst_ctrl
  import bcs_pkg::*;
#(
  parameter int NUM_SLOTS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_vld_i,
  input  logic [DATA_W-1:0]    cmd_i,
  output logic [NUM_SLOTS-1:0] clk_en_o,
  output logic [NUM_SLOTS-1:0] slot_rst_o,
  output logic                 pll_en_o,
  output logic [DATA_W-1:0]    status_o
);
  // field packing requires NUM_SLOTS + 1 <= 4
  logic unused_cmd;
  assign unused_cmd = ^cmd_i;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        clk_en_o[g]   <= 1'b0;
        slot_rst_o[g] <= 1'b1;
      end else if (cmd_vld_i) begin
        if (cmd_i[CLK_OFF_LSB+g])     clk_en_o[g] <= 1'b0;
        else if (cmd_i[CLK_ON_LSB+g]) clk_en_o[g] <= 1'b1;
        if (cmd_i[RST_ON_LSB+g])       slot_rst_o[g] <= 1'b1;
        else if (cmd_i[RST_OFF_LSB+g]) slot_rst_o[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pll_en_o <= 1'b0;
    end else if (cmd_vld_i) begin
      if (cmd_i[CLK_OFF_LSB+NUM_SLOTS])     pll_en_o <= 1'b0;
      else if (cmd_i[CLK_ON_LSB+NUM_SLOTS]) pll_en_o <= 1'b1;
    end
  end

  always_comb begin
    status_o = '0;
    status_o[STAT_CLK_LSB +: NUM_SLOTS]  = clk_en_o;
    status_o[STAT_CLK_LSB + NUM_SLOTS]   = pll_en_o;
    status_o[STAT_RST_LSB +: NUM_SLOTS]  = slot_rst_o;
  end
endmodule

// File: rtl/bcs_regfile.sv
module bcs_regfile
  import bcs_pkg::*;
#(
  parameter logic [DATA_W-1:0] SIGNATURE_VAL = 32'h5A17_0C31,
  parameter logic [DATA_W-1:0] REVISION_VAL  = 32'h2403_1200,
  parameter logic [DATA_W-1:0] OLDEST_VAL    = 32'h2311_0500,
  parameter logic [DATA_W-1:0] BUILD_ID_VAL  = 32'h0BAD_F00D,
  parameter int                SYNC_STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] ctrl_status_i,
  input  logic              partner_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ctrl_wr_o,
  output logic              host_ready_o
);
  reg_sel_e          sel;
  logic              partner_s;
  logic [DATA_W-1:0] scratch_q, dio_q, ser_lo_q, ser_hi_q;
  logic              ready_q;

  assign sel = decode_addr(addr_i);

  bcs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) i_partner_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (partner_i),
    .q_o    (partner_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scratch_q <= '0;
      dio_q     <= '0;
      ser_lo_q  <= '0;
      ser_hi_q  <= '0;
      ready_q   <= 1'b0;
    end else if (wr_i) begin
      case (sel)
        SEL_SCRATCH: scratch_q <= wr_data_i;
        SEL_DIO:     dio_q     <= wr_data_i;
        SEL_SER_LO:  ser_lo_q  <= wr_data_i;
        SEL_SER_HI:  ser_hi_q  <= wr_data_i;
        SEL_LINK:    ready_q   <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_SIG:     rd_data_o = SIGNATURE_VAL;
      SEL_COMPAT:  rd_data_o = REVISION_VAL;
      SEL_OLDEST:  rd_data_o = OLDEST_VAL;
      SEL_SCRATCH: rd_data_o = scratch_q;
      SEL_HASH:    rd_data_o = BUILD_ID_VAL;
      SEL_CTRL:    rd_data_o = ctrl_status_i;
      SEL_DIO:     rd_data_o = dio_q;
      SEL_SER_LO:  rd_data_o = ser_lo_q;
      SEL_SER_HI:  rd_data_o = ser_hi_q;
      SEL_LINK:    rd_data_o = {{(DATA_W-1){1'b0}}, partner_s};
      default:     rd_data_o = '0;
    endcase
  end

  assign ctrl_wr_o    = wr_i && (sel == SEL_CTRL);
  assign host_ready_o = ready_q;
endmodule

// File: rtl/board_ctrl_spi.sv
module board_ctrl_spi
  import bcs_pkg::*;
#(
  parameter int                NUM_SLOTS     = 2,
  parameter int                SYNC_STAGES   = 2,
  parameter logic [DATA_W-1:0] SIGNATURE_VAL = 32'h5A17_0C31,
  parameter logic [DATA_W-1:0] REVISION_VAL  = 32'h2403_1200,
  parameter logic [DATA_W-1:0] OLDEST_VAL    = 32'h2311_0500,
  parameter logic [DATA_W-1:0] BUILD_ID_VAL  = 32'h0BAD_F00D
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 spi_sck_i,
  input  logic                 spi_cs_ni,
  input  logic                 spi_mosi_i,
  output logic                 spi_miso_o,
  input  logic                 partner_found_i,
  output logic                 host_ready_o,
  output logic [NUM_SLOTS-1:0] slot_clk_en_o,
  output logic [NUM_SLOTS-1:0] slot_rst_o,
  output logic                 pll_ref_en_o
);
  logic              cs_idle, wr_stb, ctrl_wr;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] wdata, rdata, ctrl_status;

  bcs_spi_link #(.SYNC_STAGES(SYNC_STAGES)) i_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_i     (spi_sck_i),
    .cs_ni     (spi_cs_ni),
    .mosi_i    (spi_mosi_i),
    .miso_o    (spi_miso_o),
    .cs_idle_o (cs_idle),
    .addr_o    (req_addr),
    .rd_data_i (rdata),
    .wr_o      (wr_stb),
    .wr_data_o (wdata)
  );

  bcs_regfile #(
    .SIGNATURE_VAL (SIGNATURE_VAL),
    .REVISION_VAL  (REVISION_VAL),
    .OLDEST_VAL    (OLDEST_VAL),
    .BUILD_ID_VAL  (BUILD_ID_VAL),
    .SYNC_STAGES   (SYNC_STAGES)
  ) i_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .addr_i        (req_addr),
    .wr_i          (wr_stb),
    .wr_data_i     (wdata),
    .ctrl_status_i (ctrl_status),
    .partner_i     (partner_found_i),
    .rd_data_o     (rdata),
    .ctrl_wr_o     (ctrl_wr),
    .host_ready_o  (host_ready_o)
  );

  bcs_clkrst_ctrl #(.NUM_SLOTS(NUM_SLOTS)) i_clkrst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_vld_i  (ctrl_wr),
    .cmd_i      (wdata),
    .clk_en_o   (slot_clk_en_o),
    .slot_rst_o (slot_rst_o),
    .pll_en_o   (pll_ref_en_o),
    .status_o   (ctrl_status)
  );
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk
  import bcs_pkg::*;
#(
  parameter int NUM_SLOTS = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cs_idle_i,
  input logic                 wr_stb_i,
  input logic                 ctrl_wr_i,
  input logic [DATA_W-1:0]    wdata_i,
  input logic                 miso_i,
  input logic [NUM_SLOTS-1:0] clk_en_i,
  input logic [NUM_SLOTS-1:0] rst_lvl_i,
  input logic                 host_ready_i
);
  // R1
  miso_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_idle_i |=> !miso_i);

  // R4
  clk_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clk_en_i) |-> $past(ctrl_wr_i));

  // R5
  rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rst_lvl_i) |-> $past(ctrl_wr_i));

  // R6
  clk_off_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && wdata_i[CLK_OFF_LSB] |=> !clk_en_i[0]);

  // R6
  rst_on_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && wdata_i[RST_ON_LSB] |=> rst_lvl_i[0]);

  // R8
  ready_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(host_ready_i) |-> $past(wr_stb_i));
endmodule

bind board_ctrl_spi bcs_chk #(.NUM_SLOTS(NUM_SLOTS)) i_bcs_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_idle_i    (cs_idle),
  .wr_stb_i     (wr_stb),
  .ctrl_wr_i    (ctrl_wr),
  .wdata_i      (wdata),
  .miso_i       (spi_miso_o),
  .clk_en_i     (slot_clk_en_o),
  .rst_lvl_i    (slot_rst_o),
  .host_ready_i (host_ready_o)
);

// File: tb/test_board_ctrl_spi.sv
`timescale 1ns/1ps
module test_board_ctrl_spi;
  localparam logic [31:0] SIG   = 32'h5A17_0C31;
  localparam logic [31:0] REV   = 32'h2403_1200;
  localparam logic [31:0] OLD   = 32'h2311_0500;
  localparam logic [31:0] BID   = 32'h0BAD_F00D;
  localparam int          HALF  = 200;
  localparam int          NVEC  = 35;
  localparam int          WDOG  = 180000;

  // {write, addr[14:0], data[31:0], expected read[31:0], requirement number[7:0]}
  localparam logic [87:0] VEC [NVEC] = '{
    {1'b0, 15'h00, 32'h0,         SIG,          8'd2},  // R2
    {1'b0, 15'h04, 32'h0,         REV,          8'd2},  // R2
    {1'b0, 15'h08, 32'h0,         OLD,          8'd2},  // R2
    {1'b0, 15'h10, 32'h0,         BID,          8'd2},  // R2
    {1'b0, 15'h0C, 32'h0,         32'h0,        8'd7},  // R7
    {1'b0, 15'h20, 32'h0,         32'h30,       8'd7},  // R7
    {1'b0, 15'h3C, 32'h0,         32'h0,        8'd8},  // R8
    {1'b1, 15'h0C, 32'hA5A51234,  32'h0,        8'd3},
    {1'b0, 15'h0C, 32'h0,         32'hA5A51234, 8'd3},  // R3
    {1'b1, 15'h30, 32'hC0FFEE01,  32'h0,        8'd3},
    {1'b1, 15'h34, 32'hDEADBEEF,  32'h0,        8'd3},
    {1'b1, 15'h38, 32'h00001234,  32'h0,        8'd3},
    {1'b0, 15'h30, 32'h0,         32'hC0FFEE01, 8'd3},  // R3
    {1'b0, 15'h34, 32'h0,         32'hDEADBEEF, 8'd3},
    {1'b0, 15'h38, 32'h0,         32'h00001234, 8'd3},
    {1'b1, 15'h00, 32'hFFFFFFFF,  32'h0,        8'd2},
    {1'b0, 15'h00, 32'h0,         SIG,          8'd2},
    {1'b0, 15'h14, 32'h0,         32'h0,        8'd9},  // R9
    {1'b1, 15'h4C, 32'h0,         32'h0,        8'd9},
    {1'b0, 15'h0C, 32'h0,         32'hA5A51234, 8'd9},
    {1'b0, 15'h0E, 32'h0,         32'h0,        8'd9},
    {1'b1, 15'h20, 32'h00000700,  32'h0,        8'd4},
    {1'b0, 15'h20, 32'h0,         32'h37,       8'd4},  // R4
    {1'b1, 15'h20, 32'h00001100,  32'h0,        8'd6},
    {1'b0, 15'h20, 32'h0,         32'h36,       8'd6},  // R6
    {1'b1, 15'h20, 32'h00000000,  32'h0,        8'd6},
    {1'b0, 15'h20, 32'h0,         32'h36,       8'd6},
    {1'b1, 15'h20, 32'h00010000,  32'h0,        8'd5},
    {1'b0, 15'h20, 32'h0,         32'h26,       8'd5},  // R5
    {1'b1, 15'h20, 32'h00120000,  32'h0,        8'd5},
    {1'b0, 15'h20, 32'h0,         32'h16,       8'd5},
    {1'b1, 15'h20, 32'h00220000,  32'h0,        8'd6},
    {1'b0, 15'h20, 32'h0,         32'h36,       8'd6},
    {1'b1, 15'h20, 32'h00004000,  32'h0,        8'd4},
    {1'b0, 15'h20, 32'h0,         32'h32,       8'd4}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, partner = 1'b0;
  logic       miso, host_ready, pll_en;
  logic [1:0] clk_en, slot_rst;
  int         n_chk = 0, n_err = 0;
  logic [31:0] rd;

  always #5 clk_i = ~clk_i;

  board_ctrl_spi #(
    .SIGNATURE_VAL(SIG), .REVISION_VAL(REV), .OLDEST_VAL(OLD), .BUILD_ID_VAL(BID)
  ) i_board_ctrl_spi (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .spi_sck_i       (sck),
    .spi_cs_ni       (cs_n),
    .spi_mosi_i      (mosi),
    .spi_miso_o      (miso),
    .partner_found_i (partner),
    .host_ready_o    (host_ready),
    .slot_clk_en_o   (clk_en),
    .slot_rst_o      (slot_rst),
    .pll_ref_en_o    (pll_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // nbits < 48 models a frame cut short by chip select
  task automatic spi_frame(input logic wr, input logic [14:0] addr, input logic [31:0] d,
                           input int nbits, output logic [31:0] rdv);
    logic [47:0] fr;
    fr  = {wr, addr, d};
    rdv = '0;
    cs_n = 1'b0;
    #(HALF);
    for (int i = 47; i >= 48 - nbits; i--) begin
      mosi = fr[i];
      #(HALF);
      if (i < 32) rdv[i] = miso;
      sck = 1'b1;
      #(HALF);
      sck = 1'b0;
    end
    #(HALF);
    cs_n = 1'b1;
    #(2*HALF);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WDOG) begin
      @(posedge clk_i);
      cyc++;
    end
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #3;
    #100 rst_ni = 1'b1;
    #100;
    // R7 reset levels at the pins
    chk("R7 clk_en", {30'b0, clk_en}, 32'h0);
    chk("R7 slot_rst", {30'b0, slot_rst}, 32'h3);
    chk("R7 pll", {31'b0, pll_en}, 32'h0);
    chk("R7 ready", {31'b0, host_ready}, 32'h0);
    chk("R1 miso idle", {31'b0, miso}, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      spi_frame(VEC[v][87], VEC[v][86:72], VEC[v][71:40], 48, rd);
      if (!VEC[v][87]) begin
        n_chk++;
        if (rd !== VEC[v][39:8]) begin
          n_err++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[v][7:0], v, rd, VEC[v][39:8]);
        end
      end
    end

    // R4 R5 pins follow the status after the table
    chk("R4 clk_en pins", {30'b0, clk_en}, 32'h2);
    chk("R4 pll pin", {31'b0, pll_en}, 32'h0);
    chk("R5 rst pins", {30'b0, slot_rst}, 32'h3);
    spi_frame(1'b1, 15'h20, 32'h00030300, 48, rd);
    chk("R4 clk_en pins both on", {30'b0, clk_en}, 32'h3);
    chk("R5 rst pins both released", {30'b0, slot_rst}, 32'h0);
    chk("R1 miso idle after frame", {31'b0, miso}, 32'h0);

    // R8 link word
    spi_frame(1'b1, 15'h3C, 32'h00000001, 48, rd);
    chk("R8 ready set", {31'b0, host_ready}, 32'h1);
    spi_frame(1'b0, 15'h3C, 32'h0, 48, rd);
    chk("R8 partner low read", rd, 32'h0);
    partner = 1'b1;
    #(4*HALF);
    spi_frame(1'b0, 15'h3C, 32'h0, 48, rd);
    chk("R8 partner high read", rd, 32'h1);
    spi_frame(1'b1, 15'h3C, 32'hFFFFFFFE, 48, rd);
    chk("R8 ready cleared by bit0", {31'b0, host_ready}, 32'h0);

    // R10 short write frame
    spi_frame(1'b1, 15'h0C, 32'h11112222, 40, rd);
    spi_frame(1'b0, 15'h0C, 32'h0, 48, rd);
    chk("R10 scratch kept", rd, 32'hA5A51234);
    spi_frame(1'b1, 15'h20, 32'h00300000, 47, rd);
    chk("R10 rst pins kept", {30'b0, slot_rst}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule